// File: doc/BRIEF.md
# Serial Register-Access Master

This block lets a host processor read or write one 8-bit register inside an external line-interface device over a short serial link. The host sees two byte registers, a control byte and a data byte. Bit 0 of the control byte selects read (1) or write (0), and bits 7:1 hold a 7-bit remote register address. Writing the control byte starts a frame. Writing the data byte only stores a value that a later write frame sends out.

Each frame lasts exactly 16 serial clocks. The first 8 clocks carry the command byte. The second 8 clocks carry the data byte, which the block shifts out on a write. On a read, the block shifts the data byte in and loads it into the data register. The block generates the serial clock from the system clock, with a programmable half period. It drives one of up to two active-low device selects, chosen when the frame starts.

Top module: `sreg_link_master`

## Requirements
- R1: After reset, `busy` is 0, `ser_clk` is 0, every `ser_cs_n` line is 1, and both `ctrl_q` and `data_q` read 0.
- R2: A control-byte write (`host_we`=1, `host_addr`=0) accepted while idle makes `busy` 1 and drives the selected `ser_cs_n` line low on the next clock.
- R3: A frame contains exactly 16 rising edges of `ser_clk`. On the first 8 edges, `ser_do` carries control bit 0 (the R/W bit) and then address bits A0 through A6, least significant bit first.
- R4: In a write frame, `ser_do` carries data-register bits D0 through D7, LSB first, on rising edges 9 to 16.
- R5: In a read frame, `ser_di` is sampled on rising edges 9 to 16, D0 first, and the resulting byte is loaded into `data_q`. During those edges `ser_do` is 0.
- R6: `ser_do` changes only when `ser_clk` falls or when a frame starts, so it is stable at every rising edge. `ser_clk` is low whenever the block is idle.
- R7: Each `ser_clk` half period lasts `cfg_half` system clocks. A value of 0 is treated as 1. So one serial period is 2×`cfg_half` system clocks.
- R8: `host_cs_sel`, captured with the control write, picks line `ser_cs_n[host_cs_sel]`. That line stays low for the whole frame, and the other line stays high.
- R9: After a frame, every select line stays high for at least one full serial period before another frame can start. `busy` stays 1 through this gap.
- R10: Host writes to either register while `busy` is 1 have no effect and start no frame. A data-byte write never starts a frame.
- R11: `ctrl_q` and `data_q` read back the last accepted control byte and data byte, or the last read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | DIV_W | Serial clock half period in system clocks (0 means 1) |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | 0 selects the control byte, 1 selects the data byte |
| host_wdata | input | 8 | Host write data |
| host_cs_sel | input | 1 | Select line used by the frame being started |
| ctrl_q | output | 8 | Control byte readback |
| data_q | output | 8 | Data byte readback |
| busy | output | 1 | Frame or recovery gap in progress |
| ser_clk | output | 1 | Generated serial clock, idles low |
| ser_cs_n | output | NUM_CS | Active-low device selects |
| ser_do | output | 1 | Serial data out |
| ser_di | input | 1 | Serial data in |

## Verification
Two things can fall in the same system clock cycle. One is a host write to the data byte. The other is the load of a read result into that same register at the final falling serial edge, and this load can also coincide with a write to the control byte. The bench provokes this by hammering writes to both registers on every cycle while `busy` is high. Afterwards, `data_q` must equal the byte the remote model returned, `ctrl_q` must be unchanged, and no extra frame may appear. A sweep over every address, both directions and both selects, run at several divider settings, checks the bit order and the timing.

// File: rtl/sreg_link_master.sv
module sreg_link_master #(
  parameter int DIV_W  = 4,
  parameter int NUM_CS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             host_we,
  input  logic             host_addr,
  input  logic [7:0]       host_wdata,
  input  logic             host_cs_sel,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       data_q,
  output logic             busy,
  output logic             ser_clk,
  output logic [NUM_CS-1:0] ser_cs_n,
  output logic             ser_do,
  input  logic             ser_di
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] tcnt;
  logic [DIV_W-1:0] half_eff;
  logic             tick;
  logic [3:0]       bitn;
  logic [15:0]      sh;
  logic [7:0]       rx;
  logic             sel_q;
  logic             gap_ph;

  assign half_eff = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
  assign tick     = (tcnt == half_eff - DIV_W'(1));
  assign busy     = (st != S_IDLE);
  assign ser_do   = (st == S_RUN) & sh[0];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    if (NUM_CS == 1) begin : g_one
      assign ser_cs_n[i] = !(st == S_RUN);
    end else begin : g_sel
      assign ser_cs_n[i] = !(st == S_RUN && sel_q == 1'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx      <= '0;
      sel_q   <= 1'b0;
      gap_ph  <= 1'b0;
      ser_clk <= 1'b0;
      ctrl_q  <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (host_we) begin
            if (!host_addr) begin
              ctrl_q <= host_wdata;
              sh     <= {host_wdata[0] ? 8'h00 : data_q, host_wdata};
              sel_q  <= host_cs_sel;
              bitn   <= '0;
              st     <= S_RUN;
            end else begin
              data_q <= host_wdata;
            end
          end
        end
        S_RUN: begin
          if (tick) begin
            tcnt <= '0;
            if (!ser_clk) begin
              ser_clk <= 1'b1;
              if (ctrl_q[0] && bitn[3]) rx <= {ser_di, rx[7:1]};
            end else begin
              ser_clk <= 1'b0;
              sh      <= sh >> 1;
              bitn    <= bitn + 4'd1;
              if (bitn == 4'd15) begin
                st     <= S_GAP;
                gap_ph <= 1'b0;
                if (ctrl_q[0]) data_q <= rx;
              end
            end
          end else begin
            tcnt <= tcnt + DIV_W'(1);
          end
        end
        default: begin
          if (tick) begin
            tcnt   <= '0;
            gap_ph <= 1'b1;
            if (gap_ph) st <= S_IDLE;
          end else begin
            tcnt <= tcnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && (&ser_cs_n)));
  assert_do_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_do));
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ser_cs_n));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_we && !host_addr) |=> (busy && !(&ser_cs_n)));
  assert_busy_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(ctrl_q));
  assert_busy_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_addr && !ctrl_q[0]) |=> $stable(data_q));
endmodule

// File: tb/tb_sreg_link_master.sv
module tb_sreg_link_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_half = 4'd1;
  logic       host_we = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       host_cs_sel = 1'b0;
  logic [7:0] ctrl_q, data_q;
  logic       busy, ser_clk, ser_do;
  logic [1:0] ser_cs_n;
  logic       ser_di = 1'b0;

  sreg_link_master #(.DIV_W(4), .NUM_CS(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_cs_sel(host_cs_sel),
    .ctrl_q(ctrl_q), .data_q(data_q), .busy(busy), .ser_clk(ser_clk),
    .ser_cs_n(ser_cs_n), .ser_do(ser_do), .ser_di(ser_di));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int heff = 1;
  int nrise = 0, frames = 0;
  logic [15:0] cap;
  logic [7:0]  rem_byte = 8'h00;
  logic [1:0]  exp_cs = 2'b11;
  time last_rise = 0, cs_up_t = 0;
  bit  have_up = 0;
  int  period_bad = 0, cs_bad = 0, gap_bad = 0, do_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge ser_clk) begin
    if (nrise < 16) cap[nrise] = ser_do;
    if (nrise > 0 && ($time - last_rise) != 8 * heff) period_bad++;
    if (ser_cs_n !== exp_cs) cs_bad++;
    last_rise = $time;
    nrise++;
  end

  always @(negedge ser_clk) begin
    if (nrise >= 8 && nrise < 16) ser_di = rem_byte[nrise-8];
  end

  logic [1:0] cs_prev = 2'b11;
  always @(ser_cs_n) begin
    if (&ser_cs_n && !(&cs_prev)) begin
      cs_up_t = $time;
      have_up = 1;
    end
    if (!(&ser_cs_n) && (&cs_prev)) begin
      frames++;
      if (have_up && ($time - cs_up_t) < 8 * heff) gap_bad++;
    end
    cs_prev = ser_cs_n;
  end

  task automatic hwrite(input bit a, input logic [7:0] d, input bit s);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d; host_cs_sel = s;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic txn(input bit rw, input logic [6:0] addr, input logic [7:0] d,
                     input bit s, input logic [7:0] rem, input bit hammer);
    logic [7:0] cb;
    int f0;
    cb = {addr, rw};
    hwrite(1'b1, d, 1'b0);
    rem_byte = rem;
    exp_cs = s ? 2'b01 : 2'b10;
    nrise = 0; period_bad = 0; cs_bad = 0; gap_bad = 0;
    hwrite(1'b0, cb, s);
    chk(busy === 1'b1 && ser_cs_n === exp_cs, "R2 start", {busy, ser_cs_n}, {1'b1, exp_cs});
    f0 = frames;
    while (busy) begin
      if (hammer) begin
        host_we = 1'b1; host_addr = ~host_addr; host_wdata = ~cb ^ 8'h5a;
      end
      @(negedge clk);
    end
    host_we = 1'b0;
    chk(nrise == 16, "R3 edge count", nrise, 16);
    chk(cap[7:0] == cb, "R3 command bits", cap[7:0], cb);
    if (rw) begin
      chk(cap[15:8] == 8'h00, "R5 sdo low in read", cap[15:8], 0);
      chk(data_q == rem, "R5 read data", data_q, rem);
    end else begin
      chk(cap[15:8] == d, "R4 write data bits", cap[15:8], d);
      chk(data_q == d, "R10 data kept", data_q, d);
    end
    chk(period_bad == 0, "R7 serial period", period_bad, 0);
    chk(cs_bad == 0, "R8 select line", cs_bad, 0);
    chk(gap_bad == 0, "R9 recovery gap", gap_bad, 0);
    chk(ctrl_q == cb, "R11 ctrl readback", ctrl_q, cb);
    if (hammer) begin
      repeat (4 * heff + 4) @(negedge clk);
      chk(frames == f0 && !busy, "R10 no extra frame", frames - f0, 0);
      chk(!ser_clk && &ser_cs_n, "R6 idle lines", {ser_clk, ser_cs_n}, 3'b011);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && ser_clk === 1'b0 && ser_cs_n === 2'b11, "R1 reset lines",
        {busy, ser_clk, ser_cs_n}, 4'b0011);
    chk(ctrl_q === 8'h00 && data_q === 8'h00, "R1 reset regs", {ctrl_q, data_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    hwrite(1'b1, 8'h3c, 1'b0);
    @(negedge clk);
    chk(!busy && frames == 0, "R10 data write no start", frames, 0);
    chk(data_q == 8'h3c, "R11 data readback", data_q, 8'h3c);

    cfg_half = 4'd1; heff = 1;
    for (int a = 0; a < 128; a++)
      for (int rw = 0; rw < 2; rw++)
        for (int s = 0; s < 2; s++)
          txn(rw[0], a[6:0], 8'(a * 37 + 11), s[0], 8'(a * 91 + rw * 7 + s), 1'b0);

    foreach (cfg_half[k]) begin end
    for (int c = 0; c < 4; c++) begin
      cfg_half = (c == 0) ? 4'd0 : (c == 1) ? 4'd2 : (c == 2) ? 4'd3 : 4'd7;
      heff = (c == 0) ? 1 : int'(cfg_half);
      for (int t = 0; t < 8; t++)
        txn(t[0], 7'(t * 19 + c), 8'(t * 53 + c), t[1], 8'(t * 29 + 200), t[2]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule